// File: doc/BRIEF.md
# One-Time Fuse Array Controller

The controller sits between a small byte-wide register bus and a one-time-programmable fuse array of `NUM_BANKS` banks, each of `WORDS_PER_BANK` byte words. Software selects a fuse through two address registers, then starts one of two timed operations through a control register. An explicit sense copies one fused word into a sense-data register. A program operation blows a single fuse bit, and only when the protect-key register already holds 0xAA. Each operation holds a busy flag for a fixed number of cycles and then raises a sticky done or error flag.

The upper half of the bus address space is an array window (address bit 11 set, bank in bits 10:8, word in bits 7:0). Writes through it go into a volatile per-word shadow. Reads return the shadow value when one has been written, and the fused value otherwise. Three per-bank protect inputs block programming, override writes and reads. The array is a behavioural model that is cleared by reset. An interrupt output combines the masked status and error flags.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, busy is low and `irq_o` is low.
- R2: Register offsets (address bit 11 = 0, low 4 bits): 0 control, 1 upper address, 2 lower address, 3 protect key, 4 status, 5 status mask, 6 error, 7 error mask, 8 sense data. Operations address the bank `upper[5:3]`, the word `{upper[2:0], lower[7:3]}` and the bit `lower[2:0]`.
- R3: Writing control bit 3 while idle starts a sense. Busy (status bit 7) is high for exactly `SENSE_CYC` (4) cycles. Then status bit 0 sets and sense data takes the fused word, ignoring any shadow value.
- R4: Writing control bit 0 while idle, with key 0xAA and the bank not write-protected, starts programming. Busy is high for `PROG_CYC` (8) cycles. Then the addressed fuse bit is set and status bit 1 sets.
- R5: A program start on a write-protected bank, or with a key other than 0xAA, sets error bit 6 at once. It never raises busy, sets no done flag and leaves the array unchanged.
- R6: Programming a bit that is already blown sets error bit 7 at the end of the operation and sets no done flag.
- R7: An array-window write stores the byte in the word's shadow, and later window reads return it. If the bank is override-protected, the write sets error bit 5 and stores nothing.
- R8: An array-window read returns the shadow if one was written, and the fused word otherwise. On a read-protected bank it returns 0x00 and sets error bit 4.
- R9: A sense on a read-protected bank runs its full length. It then sets error bit 2 and leaves status bit 0 and the sense data unchanged.
- R10: Writing 1 to a status or error bit clears it. Bits written 0 keep their value.
- R11: Control bits 0 and 3 always read 0. Bits 7:4 and 2:1 read back as written. A start written while busy is dropped.
- R12: `irq_o` is high while any status flag and its status-mask bit are both set, or any error flag and its error-mask bit are both set.
- R13: The key must equal exactly 0xAA. Any other value makes a program start fail as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Bus write strobe |
| reg_re_i | input | 1 | Bus read strobe; data is valid one cycle later |
| reg_addr_i | input | ADDR_W (12) | Register offset, or array window when the top bit is set |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| wr_prot_i | input | NUM_BANKS | Per-bank program protect |
| rd_prot_i | input | NUM_BANKS | Per-bank read protect |
| ovr_prot_i | input | NUM_BANKS | Per-bank override protect |
| irq_o | output | 1 | Masked flag interrupt |

## Verification
The assertions assume the bus never raises write and read strobes together. They also assume the protect inputs stay stable while an operation runs, because the read-protect bit is sampled when a sense finishes. The stimulus drives one bus access at a time on the falling clock edge and changes the protect inputs only while the block is idle. It never writes a clear to a flag in the same cycle that an operation sets that flag, so the order of set and clear is never tested.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned REG_AW = 4;

  localparam logic [REG_AW-1:0] OFS_FCTL  = 4'd0;
  localparam logic [REG_AW-1:0] OFS_UADDR = 4'd1;
  localparam logic [REG_AW-1:0] OFS_LADDR = 4'd2;
  localparam logic [REG_AW-1:0] OFS_KEY   = 4'd3;
  localparam logic [REG_AW-1:0] OFS_STAT  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_SMASK = 4'd5;
  localparam logic [REG_AW-1:0] OFS_ERR   = 4'd6;
  localparam logic [REG_AW-1:0] OFS_EMASK = 4'd7;
  localparam logic [REG_AW-1:0] OFS_SDAT  = 4'd8;

  localparam int unsigned ST_BUSY  = 7;
  localparam int unsigned ST_PDONE = 1;
  localparam int unsigned ST_SDONE = 0;

  localparam int unsigned ER_PRG = 7;
  localparam int unsigned ER_WP  = 6;
  localparam int unsigned ER_OVR = 5;
  localparam int unsigned ER_RP  = 4;
  localparam int unsigned ER_SNS = 2;

  localparam int unsigned FC_PRG = 0;
  localparam int unsigned FC_SNS = 3;
  localparam logic [7:0]  FC_KEEP = 8'hF6;

  localparam logic [7:0] PROG_KEY = 8'hAA;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SENSE = 2'd1,
    OP_PROG  = 2'd2
  } op_e;
endpackage

// File: rtl/fuse_cells.sv
module fuse_cells #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [7:0]       rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [7:0]       rd_b_o,
  input  logic             blow_i,
  input  logic [IDX_W-1:0] blow_idx_i,
  input  logic [2:0]       blow_bit_i
);
  logic [7:0] cell_q [DEPTH];

  // reset models a virgin array
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) cell_q[i] <= '0;
    end else if (blow_i) begin
      cell_q[blow_idx_i][blow_bit_i] <= 1'b1;
    end
  end

  assign rd_a_o = cell_q[rd_a_idx_i];
  assign rd_b_o = cell_q[rd_b_idx_i];
endmodule

// File: rtl/fuse_shadow.sv
module fuse_shadow #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_hit_o
);
  logic [7:0]       data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) data_q[i] <= '0;
    end else if (wr_i) begin
      vld_q[wr_idx_i]  <= 1'b1;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = data_q[rd_idx_i];
  assign rd_hit_o  = vld_q[rd_idx_i];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned SENSE_CYC = 4,
  parameter int unsigned PROG_CYC  = 8,
  localparam int unsigned BANK_W  = $clog2(NUM_BANKS),
  localparam int unsigned MAX_CYC = (SENSE_CYC > PROG_CYC) ? SENSE_CYC : PROG_CYC,
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sense_req_i,
  input  logic                 prog_req_i,
  input  logic                 key_ok_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [2:0]           bit_i,
  input  logic [NUM_BANKS-1:0] wr_prot_i,
  input  logic [NUM_BANKS-1:0] rd_prot_i,
  input  logic [7:0]           cell_i,
  output logic [IDX_W-1:0]     op_idx_o,
  output logic                 busy_o,
  output logic                 sense_done_o,
  output logic                 prog_done_o,
  output logic                 prg_err_o,
  output logic                 wp_err_o,
  output logic                 sns_err_o,
  output logic                 sdat_load_o,
  output logic                 blow_o,
  output logic [2:0]           blow_bit_o
);
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [2:0]         bit_q;
  logic [BANK_W-1:0]  req_bank, op_bank;
  logic idle, accept_prog, prog_ok, start_prog, start_sense, finish;

  assign req_bank    = idx_i[IDX_W-1 -: BANK_W];
  assign op_bank     = idx_q[IDX_W-1 -: BANK_W];
  assign idle        = (op_q == OP_IDLE);
  assign accept_prog = idle && prog_req_i;
  assign prog_ok     = key_ok_i && !wr_prot_i[req_bank];
  assign start_prog  = accept_prog && prog_ok;
  assign start_sense = idle && sense_req_i && !prog_req_i;
  assign finish      = !idle && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      bit_q <= '0;
    end else if (start_prog) begin
      op_q  <= OP_PROG;
      cnt_q <= CNT_W'(PROG_CYC - 1);
      idx_q <= idx_i;
      bit_q <= bit_i;
    end else if (start_sense) begin
      op_q  <= OP_SENSE;
      cnt_q <= CNT_W'(SENSE_CYC - 1);
      idx_q <= idx_i;
      bit_q <= bit_i;
    end else if (finish) begin
      op_q <= OP_IDLE;
    end else if (!idle) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  logic sense_end, prog_end, blown;
  assign sense_end = finish && (op_q == OP_SENSE);
  assign prog_end  = finish && (op_q == OP_PROG);
  assign blown     = cell_i[bit_q];

  assign op_idx_o     = idx_q;
  assign busy_o       = !idle;
  assign wp_err_o     = accept_prog && !prog_ok;
  assign sns_err_o    = sense_end && rd_prot_i[op_bank];
  assign sense_done_o = sense_end && !rd_prot_i[op_bank];
  assign sdat_load_o  = sense_done_o;
  assign prg_err_o    = prog_end && blown;
  assign prog_done_o  = prog_end && !blown;
  assign blow_o       = prog_done_o;
  assign blow_bit_o   = bit_q;
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 8,
  parameter int unsigned WORDS_PER_BANK = 256,
  parameter int unsigned SENSE_CYC      = 4,
  parameter int unsigned PROG_CYC       = 8,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned WORD_W = $clog2(WORDS_PER_BANK),
  localparam int unsigned ADDR_W = BANK_W + WORD_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic [NUM_BANKS-1:0] wr_prot_i,
  input  logic [NUM_BANKS-1:0] rd_prot_i,
  input  logic [NUM_BANKS-1:0] ovr_prot_i,
  output logic                 irq_o
);
  localparam int unsigned IDX_W = BANK_W + WORD_W;
  localparam int unsigned DEPTH = NUM_BANKS * WORDS_PER_BANK;

  logic              arr_sel, wr_reg, rd_reg, arr_wr, arr_rd;
  logic [REG_AW-1:0] ofs;
  logic [IDX_W-1:0]  arr_idx, op_idx, seq_idx;
  logic [BANK_W-1:0] arr_bank;

  assign arr_sel  = reg_addr_i[ADDR_W-1];
  assign ofs      = reg_addr_i[REG_AW-1:0];
  assign arr_idx  = reg_addr_i[IDX_W-1:0];
  assign arr_bank = arr_idx[IDX_W-1 -: BANK_W];
  assign wr_reg   = reg_we_i && !arr_sel;
  assign rd_reg   = reg_re_i && !arr_sel;
  assign arr_wr   = reg_we_i && arr_sel;
  assign arr_rd   = reg_re_i && arr_sel;

  logic [7:0] fctl_q, ua_q, la_q, key_q, smask_q, err_q, emask_q, sdat_q, rdata_q;
  logic       sdone_q, pdone_q;

  // bank | word | bit packed across the two address registers
  assign op_idx = {ua_q[3 +: BANK_W], ua_q[2:0], la_q[7:3]};

  logic sense_req, prog_req, key_ok;
  assign sense_req = wr_reg && (ofs == OFS_FCTL) && reg_wdata_i[FC_SNS];
  assign prog_req  = wr_reg && (ofs == OFS_FCTL) && reg_wdata_i[FC_PRG];
  assign key_ok    = (key_q == PROG_KEY);

  logic [7:0] cell_a, cell_b, shd_data;
  logic       shd_hit;
  logic       busy, sense_done, prog_done, prg_err, wp_err, sns_err, sdat_load, blow;
  logic [2:0] blow_bit;

  fuse_seq #(
    .NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .SENSE_CYC(SENSE_CYC), .PROG_CYC(PROG_CYC)
  ) i_seq (
    .clk_i, .rst_ni,
    .sense_req_i (sense_req),
    .prog_req_i  (prog_req),
    .key_ok_i    (key_ok),
    .idx_i       (op_idx),
    .bit_i       (la_q[2:0]),
    .wr_prot_i,
    .rd_prot_i,
    .cell_i      (cell_b),
    .op_idx_o    (seq_idx),
    .busy_o      (busy),
    .sense_done_o(sense_done),
    .prog_done_o (prog_done),
    .prg_err_o   (prg_err),
    .wp_err_o    (wp_err),
    .sns_err_o   (sns_err),
    .sdat_load_o (sdat_load),
    .blow_o      (blow),
    .blow_bit_o  (blow_bit)
  );

  fuse_cells #(.DEPTH(DEPTH)) i_cells (
    .clk_i, .rst_ni,
    .rd_a_idx_i (arr_idx),
    .rd_a_o     (cell_a),
    .rd_b_idx_i (seq_idx),
    .rd_b_o     (cell_b),
    .blow_i     (blow),
    .blow_idx_i (seq_idx),
    .blow_bit_i (blow_bit)
  );

  logic ovr_blk, rd_blk;
  assign ovr_blk = arr_wr && ovr_prot_i[arr_bank];
  assign rd_blk  = arr_rd && rd_prot_i[arr_bank];

  fuse_shadow #(.DEPTH(DEPTH)) i_shadow (
    .clk_i, .rst_ni,
    .wr_i      (arr_wr && !ovr_blk),
    .wr_idx_i  (arr_idx),
    .wr_data_i (reg_wdata_i),
    .rd_idx_i  (arr_idx),
    .rd_data_o (shd_data),
    .rd_hit_o  (shd_hit)
  );

  logic [7:0] err_set, err_clr;
  logic [1:0] st_clr;
  always_comb begin
    err_set         = '0;
    err_set[ER_PRG] = prg_err;
    err_set[ER_WP]  = wp_err;
    err_set[ER_OVR] = ovr_blk;
    err_set[ER_RP]  = rd_blk;
    err_set[ER_SNS] = sns_err;
    err_clr = (wr_reg && ofs == OFS_ERR) ? reg_wdata_i : '0;
    st_clr  = (wr_reg && ofs == OFS_STAT) ? reg_wdata_i[1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q  <= '0;
      ua_q    <= '0;
      la_q    <= '0;
      key_q   <= '0;
      smask_q <= '0;
      emask_q <= '0;
      err_q   <= '0;
      sdone_q <= 1'b0;
      pdone_q <= 1'b0;
      sdat_q  <= '0;
    end else begin
      if (wr_reg) begin
        unique case (ofs)
          OFS_FCTL:  fctl_q  <= reg_wdata_i & FC_KEEP;
          OFS_UADDR: ua_q    <= reg_wdata_i;
          OFS_LADDR: la_q    <= reg_wdata_i;
          OFS_KEY:   key_q   <= reg_wdata_i;
          OFS_SMASK: smask_q <= reg_wdata_i;
          OFS_EMASK: emask_q <= reg_wdata_i;
          default: ;
        endcase
      end
      err_q   <= (err_q & ~err_clr) | err_set;
      sdone_q <= (sdone_q & ~st_clr[ST_SDONE]) | sense_done;
      pdone_q <= (pdone_q & ~st_clr[ST_PDONE]) | prog_done;
      if (sdat_load) sdat_q <= cell_b;
    end
  end

  logic [7:0] stat_v, reg_v, rd_v;
  assign stat_v = {busy, 5'b0, pdone_q, sdone_q};

  always_comb begin
    unique case (ofs)
      OFS_FCTL:  reg_v = fctl_q;
      OFS_UADDR: reg_v = ua_q;
      OFS_LADDR: reg_v = la_q;
      OFS_KEY:   reg_v = key_q;
      OFS_STAT:  reg_v = stat_v;
      OFS_SMASK: reg_v = smask_q;
      OFS_ERR:   reg_v = err_q;
      OFS_EMASK: reg_v = emask_q;
      OFS_SDAT:  reg_v = sdat_q;
      default:   reg_v = '0;
    endcase
    if (!arr_sel)     rd_v = reg_v;
    else if (rd_blk)  rd_v = '0;
    else if (shd_hit) rd_v = shd_data;
    else              rd_v = cell_a;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (rd_reg || arr_rd)  rdata_q <= rd_v;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o = |(stat_v & smask_q) || |(err_q & emask_q);
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk #(
  parameter int unsigned SENSE_CYC = 4,
  parameter int unsigned PROG_CYC  = 8,
  localparam int unsigned MAX_CYC = (SENSE_CYC > PROG_CYC) ? SENSE_CYC : PROG_CYC
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sense_req,
  input logic       prog_req,
  input logic       key_ok,
  input logic       busy,
  input logic       sdone_q,
  input logic       pdone_q,
  input logic [7:0] smask_q,
  input logic [7:0] emask_q,
  input logic       irq_o
);
  int unsigned busy_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  AST_SENSE_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && sense_req && !prog_req) |=> busy); // R3
  AST_SDONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdone_q) |-> $past(busy)); // R3
  AST_PDONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdone_q) |-> $past(busy)); // R4
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (busy_run < MAX_CYC)); // R4
  AST_BAD_KEY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && prog_req && !key_ok) |=> !busy); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smask_q == 8'h00 && emask_q == 8'h00) |-> !irq_o); // R12
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.SENSE_CYC(SENSE_CYC), .PROG_CYC(PROG_CYC)) i_fuse_ctrl_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sense_req (sense_req),
  .prog_req  (prog_req),
  .key_ok    (key_ok),
  .busy      (busy),
  .sdone_q   (sdone_q),
  .pdone_q   (pdone_q),
  .smask_q   (smask_q),
  .emask_q   (emask_q),
  .irq_o     (irq_o)
);

// File: tb/test_fuse_ctrl.sv
module test_fuse_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 8;
  localparam int SENSE_CYC  = 4;

  localparam logic [11:0] A_FCTL = 12'h000, A_UA = 12'h001, A_LA = 12'h002, A_KEY = 12'h003;
  localparam logic [11:0] A_STAT = 12'h004, A_SMASK = 12'h005, A_ERR = 12'h006;
  localparam logic [11:0] A_EMASK = 12'h007, A_SDAT = 12'h008;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [7:0]  wr_prot = '0, rd_prot = '0, ovr_prot = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_ctrl #(.SENSE_CYC(SENSE_CYC), .PROG_CYC(PROG_CYC)) i_fuse_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .wr_prot_i(wr_prot), .rd_prot_i(rd_prot), .ovr_prot_i(ovr_prot), .irq_o(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       re_seen = 1'b0;
  always @(posedge clk) re_seen <= reg_re;
  always @(negedge clk) begin
    if (re_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(int'(reg_rdata), int'(e), t);
    end
  end

  // busy run tracker: irq follows busy while only status-mask bit 7 is set
  int run = 0, last_run = 0, events = 0;
  always @(negedge clk) begin
    if (irq) run++;
    else if (run > 0) begin
      last_run = run;
      run = 0;
      events++;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic settle();
    repeat (PROG_CYC + 4) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int ev0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    chk(int'(irq), 0, "R1 irq after reset");
    rd(A_STAT, 8'h00, "R1 status");
    rd(A_ERR,  8'h00, "R1 error");
    rd(A_FCTL, 8'h00, "R1 control");
    rd(A_SDAT, 8'h00, "R1 sense data");
    rd(A_KEY,  8'h00, "R1 key");

    // R2/R4: bank 2, word 0x25, bit 3
    wr(A_SMASK, 8'h80);
    wr(A_UA, 8'h11);
    wr(A_LA, 8'h2B);
    wr(A_KEY, 8'hAA);
    ev0 = events;
    wr(A_FCTL, 8'h01);
    settle();
    chk(events - ev0, 1, "R4 one busy period");
    chk(last_run, PROG_CYC, "R4 busy length");
    rd(A_STAT, 8'h02, "R4 program done");
    wr(A_KEY, 8'h00);

    // R3 sense
    wr(A_FCTL, 8'h08);
    settle();
    chk(last_run, SENSE_CYC, "R3 busy length");
    rd(A_STAT, 8'h03, "R3 sense done");
    rd(A_SDAT, 8'h08, "R3 R2 sensed word");
    rd(A_FCTL, 8'h00, "R11 start bits self clear");
    rd(12'hA25, 8'h08, "R8 window read of fuse");

    // R10
    wr(A_STAT, 8'h02);
    rd(A_STAT, 8'h01, "R10 clear program done only");
    wr(A_STAT, 8'h01);
    rd(A_STAT, 8'h00, "R10 clear sense done");

    // R13/R5 wrong key, bit 5
    wr(A_KEY, 8'hAB);
    wr(A_LA, 8'h2D);
    ev0 = events;
    wr(A_FCTL, 8'h01);
    settle();
    chk(events - ev0, 0, "R5 no busy on bad key");
    rd(A_ERR, 8'h40, "R13 write-protect error on bad key");
    rd(A_STAT, 8'h00, "R5 no done flag");
    wr(A_FCTL, 8'h08);
    settle();
    rd(A_SDAT, 8'h08, "R5 array unchanged");
    wr(A_ERR, 8'h40);
    wr(A_STAT, 8'h01);
    rd(A_ERR, 8'h00, "R10 error cleared");

    // R5 protected bank
    wr(A_KEY, 8'hAA);
    wr_prot = 8'h04;
    ev0 = events;
    wr(A_FCTL, 8'h01);
    settle();
    chk(events - ev0, 0, "R5 no busy on protected bank");
    rd(A_ERR, 8'h40, "R5 write-protect error");
    wr(A_ERR, 8'h40);
    wr_prot = 8'h00;

    // R6 already blown bit 3
    wr(A_LA, 8'h2B);
    wr(A_FCTL, 8'h01);
    settle();
    chk(last_run, PROG_CYC, "R6 busy length");
    rd(A_ERR, 8'h80, "R6 program error");
    rd(A_STAT, 8'h00, "R6 no done flag");
    wr(A_ERR, 8'h80);
    wr(A_KEY, 8'h00);

    // R7 override
    wr(12'hA25, 8'h5A);
    rd(12'hA25, 8'h5A, "R7 shadow read");
    rd(A_ERR, 8'h00, "R7 no error");
    wr(A_FCTL, 8'h08);
    settle();
    rd(A_SDAT, 8'h08, "R3 R7 sense ignores shadow");
    wr(A_STAT, 8'h01);
    ovr_prot = 8'h10;
    wr(12'hC10, 8'h33);
    rd(A_ERR, 8'h20, "R7 override-protect error");
    rd(12'hC10, 8'h00, "R7 blocked write not stored");
    wr(A_ERR, 8'h20);
    ovr_prot = 8'h00;

    // R8 read protect
    rd_prot = 8'h04;
    rd(12'hA25, 8'h00, "R8 protected read returns zero");
    rd(A_ERR, 8'h10, "R8 read-protect error");
    wr(A_ERR, 8'h10);

    // R9 sense word 0x26 on protected bank
    wr(A_LA, 8'h30);
    wr(A_FCTL, 8'h08);
    settle();
    chk(last_run, SENSE_CYC, "R9 full sense length");
    rd(A_STAT, 8'h00, "R9 no sense done");
    rd(A_ERR, 8'h04, "R9 sense error");
    rd(A_SDAT, 8'h08, "R9 sense data kept");
    wr(A_ERR, 8'h04);
    rd_prot = 8'h00;

    // R11 start while busy dropped (bit 6 of word 0x25)
    wr(A_LA, 8'h2E);
    wr(A_KEY, 8'hAA);
    ev0 = events;
    wr(A_FCTL, 8'h08);
    wr(A_FCTL, 8'h01);
    settle();
    chk(events - ev0, 1, "R11 single busy period");
    chk(last_run, SENSE_CYC, "R11 only sense ran");
    rd(A_STAT, 8'h01, "R11 no program done");
    rd(A_ERR, 8'h00, "R11 no error from dropped start");
    wr(A_STAT, 8'h01);
    wr(A_FCTL, 8'h08);
    settle();
    rd(A_SDAT, 8'h08, "R11 bit 6 not blown");
    wr(A_STAT, 8'h01);
    wr(A_KEY, 8'h00);
    wr(A_FCTL, 8'hF6);
    rd(A_FCTL, 8'hF6, "R11 stored control bits");

    // R12 interrupt
    wr(A_SMASK, 8'h00);
    chk(int'(irq), 0, "R12 irq masked");
    wr(A_EMASK, 8'h40);
    wr(A_FCTL, 8'h01);
    chk(int'(irq), 1, "R12 irq on masked error");
    wr(A_ERR, 8'h40);
    chk(int'(irq), 0, "R12 irq drops on clear");
    wr(A_SMASK, 8'h01);
    wr(A_FCTL, 8'h08);
    settle();
    chk(int'(irq), 1, "R12 irq on sense done");
    wr(A_STAT, 8'h01);
    chk(int'(irq), 0, "R12 irq drops after status clear");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    summary();
  end
endmodule